// File: doc/BRIEF.md
# PAM4 PWM Pre-Emphasis Symbol Generator

This block is a digital, oversampled model of a dual-mode transmit data path for a wireline link. Each unit interval (UI) is divided into a fixed number of output phases. At the start of every UI the block accepts one 2-bit symbol. It maps that symbol onto a 3-lane thermometer word. The three lanes carry equal weight, so their sum forms a 4-level signal.

Pre-emphasis needs only one setting, the duty count. For the first part of the UI the lanes carry the thermometer word. For the rest of the UI they carry its complement. Each lane therefore makes a positive pulse followed by a negative pulse inside a single UI, and this cuts the low-frequency content of the signal. A bypass setting turns the complement off and gives plain NRZ symbols. A 2-level setting ignores the low symbol bit, so only the two outermost levels are used.

The block also drives a signed level code, equal to the number of lanes at 1 minus the number at 0. The symbol source sees a ready strobe that marks the phase whose closing clock edge takes the next symbol.

Top module: `pam_pwm_tx`

## Requirements
- R1: A synchronous active-high reset sets the phase to 0, stores symbol 00 and turns bypass on. After reset is released, the lanes read 000 and the level reads -3 for the whole first UI, and `sym_ready` is low until phase 15.
- R2: `sym_ready` is high only in the last phase (15) of a UI. The clock edge that ends that phase loads the symbol, the duty count, the 2-level setting and the bypass setting, and the phase wraps to 0. If `sym_valid` is low at that edge, symbol 00 is loaded.
- R3: The symbol {msb,lsb} maps to lanes[2:0] as 00→000, 01→001, 11→011, 10→111. Lane 0 is the first lane to turn on.
- R4: With bypass off and a duty count D, phases 0 to D-1 carry the thermometer word and phases D to 15 carry its bitwise complement.
- R5: A duty value below 8 acts as 8. A duty value above 12 acts as 12.
- R6: With bypass on, the lanes hold the thermometer word unchanged for all 16 phases of the UI.
- R7: In 2-level mode the low symbol bit is treated as 0. Symbols then give only lanes 000 or 111.
- R8: `level` is the number of lanes at 1 minus the number at 0, in 3-bit two's complement (-3=101, -1=111, +1=001, +3=011).
- R9: Changes to the symbol, duty, mode or bypass inputs during phases 0 to 14 have no effect on the outputs of the current UI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per output phase |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_msb | input | 1 | Symbol high bit |
| sym_lsb | input | 1 | Symbol low bit |
| sym_ready | output | 1 | The next edge takes the offered symbol |
| duty_cfg | input | 5 | Count of non-inverted phases per UI |
| two_level | input | 1 | 2-level mode, low symbol bit ignored |
| pe_off | input | 1 | Bypass, NRZ output |
| lanes | output | 3 | Thermometer lane outputs for this phase |
| level | output | 3 | Signed lane sum, two's complement |
| ui_phase | output | 4 | Current phase within the UI |

## Verification
If the phase counter goes wrong, the ready strobe and `ui_phase` are wrong within one cycle. The inversion point also moves, and that error shows up inside the same UI. If a latched setting is wrong (level index, duty, mode or bypass), the fault appears at the ports in the first phase where that setting matters, and this is never more than one UI after the boundary that loaded it. A setting that leaks through mid-UI changes the lanes before the next boundary. Comparing every phase against a behavioural model therefore catches each of these faults within one UI of the fault.

// File: rtl/pam_pwm_tx.sv
module pam_pwm_tx #(
  parameter int PHASES   = 16,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 12,
  localparam int PW = $clog2(PHASES),
  localparam int DW = $clog2(PHASES + 1),
  localparam int NL = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sym_valid,
  input  logic          sym_msb,
  input  logic          sym_lsb,
  output logic          sym_ready,
  input  logic [DW-1:0] duty_cfg,
  input  logic          two_level,
  input  logic          pe_off,
  output logic [NL-1:0] lanes,
  output logic [2:0]    level,
  output logic [PW-1:0] ui_phase
);

  logic [PW-1:0] ph;
  logic [1:0]    idx_q;
  logic [DW-1:0] duty_q;
  logic          pe_off_q;
  logic          two_q;

  wire last = (ph == PW'(PHASES - 1));

  wire       m_eff = sym_valid & sym_msb;
  wire       l_eff = sym_valid & ~two_level & sym_lsb;
  wire [1:0] idx_n = {m_eff, m_eff ^ l_eff};

  logic [DW-1:0] duty_n;
  always_comb begin
    if (duty_cfg < DW'(DUTY_MIN))      duty_n = DW'(DUTY_MIN);
    else if (duty_cfg > DW'(DUTY_MAX)) duty_n = DW'(DUTY_MAX);
    else                               duty_n = duty_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      idx_q    <= 2'd0;
      duty_q   <= DW'(DUTY_MIN);
      pe_off_q <= 1'b1;
      two_q    <= 1'b0;
    end else begin
      ph <= last ? '0 : ph + 1'b1;
      if (last) begin
        idx_q    <= idx_n;
        duty_q   <= duty_n;
        pe_off_q <= pe_off;
        two_q    <= two_level;
      end
    end
  end

  logic [NL-1:0] therm;
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign therm[i] = (idx_q > 2'(i));
  end

  wire       hi   = pe_off_q | (DW'(ph) < duty_q);
  wire [1:0] ones = hi ? idx_q : 2'd3 - idx_q;

  assign lanes     = hi ? therm : ~therm;
  assign level     = {ones, 1'b0} + 3'b101;
  assign sym_ready = last;
  assign ui_phase  = ph;

endmodule

// File: rtl/pam_pwm_tx_chk.sv
module pam_pwm_tx_chk #(
  parameter int PHASES   = 16,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 12,
  localparam int PW = $clog2(PHASES)
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] ph,
  input logic [2:0]    lanes,
  input logic [2:0]    level,
  input logic          ready,
  input logic          two_q,
  input logic          pe_off_q
);

  // R8
  level_sum_chk: assert property (@(posedge clk) disable iff (rst)
    level == 3'(2 * $countones(lanes) - 3));

  // R2
  ready_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ph == '0));

  // R3
  head_therm_chk: assert property (@(posedge clk) disable iff (rst)
    (ph < PW'(DUTY_MIN)) |-> (lanes == 3'b000 || lanes == 3'b001 || lanes == 3'b011 || lanes == 3'b111));

  // R4
  tail_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (ph >= PW'(DUTY_MAX) && !pe_off_q) |-> (lanes == 3'b111 || lanes == 3'b110 || lanes == 3'b100 || lanes == 3'b000));

  // R7
  two_level_chk: assert property (@(posedge clk) disable iff (rst)
    two_q |-> (lanes == 3'b000 || lanes == 3'b111));

  // R9
  ui_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph != '0) |-> (lanes == $past(lanes) || lanes == ~$past(lanes)));

  // R6
  bypass_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_off_q && ph != '0) |-> $stable(lanes));

endmodule

bind pam_pwm_tx pam_pwm_tx_chk #(
  .PHASES(PHASES), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
) u_chk (
  .clk(clk), .rst(rst), .ph(ph), .lanes(lanes), .level(level),
  .ready(sym_ready), .two_q(two_q), .pe_off_q(pe_off_q)
);

// File: tb/pam_pwm_tx_bench.sv
`timescale 1ns/1ps
module pam_pwm_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0, sym_msb = 1'b0, sym_lsb = 1'b0;
  logic [4:0] duty_cfg = 5'd10;
  logic       two_level = 1'b0, pe_off = 1'b1;
  logic       sym_ready;
  logic [2:0] lanes, level;
  logic [3:0] ui_phase;

  pam_pwm_tx u_pam_pwm_tx (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_msb(sym_msb), .sym_lsb(sym_lsb),
    .sym_ready(sym_ready), .duty_cfg(duty_cfg), .two_level(two_level), .pe_off(pe_off),
    .lanes(lanes), .level(level), .ui_phase(ui_phase)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  int r_ph, r_idx, r_duty;
  bit r_byp, r_two;

  function automatic int gray_level(bit m, bit l);
    case ({m, l})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      r_ph = 0; r_idx = 0; r_duty = 8; r_byp = 1; r_two = 0;
    end else begin
      if (r_ph == 15) begin
        r_idx  = gray_level(sym_valid && sym_msb, sym_valid && !two_level && sym_lsb);
        r_duty = (duty_cfg < 8) ? 8 : (duty_cfg > 12) ? 12 : int'(duty_cfg);
        r_byp  = pe_off;
        r_two  = two_level;
      end
      r_ph = (r_ph + 1) % 16;
    end
  end

  task automatic check_now();
    bit hi;
    int th, exp_l, exp_lvl;
    hi = r_byp || (r_ph < r_duty);
    th = (1 << r_idx) - 1;
    exp_l = hi ? th : (~th & 7);
    exp_lvl = hi ? (2 * r_idx - 3) : (3 - 2 * r_idx);
    checks++;
    if (int'(lanes) != exp_l) begin
      failures++;
      $display("FAIL %s lanes phase=%0d actual=%b expected=%03b", tag, r_ph, lanes, exp_l[2:0]);
    end
    if (int'($signed(level)) != exp_lvl) begin
      failures++;
      $display("FAIL R8 level phase=%0d actual=%0d expected=%0d", r_ph, $signed(level), exp_lvl);
    end
    if (sym_ready != (r_ph == 15) || int'(ui_phase) != r_ph) begin
      failures++;
      $display("FAIL R2 ready/phase actual=%b/%0d expected=%b/%0d", sym_ready, ui_phase, r_ph == 15, r_ph);
    end
  endtask

  task automatic run(int n, bit rnd_valid, bit rnd_cfg);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      sym_msb   = 1'($urandom);
      sym_lsb   = 1'($urandom);
      sym_valid = rnd_valid ? 1'($urandom) : 1'b1;
      if (rnd_cfg) begin
        duty_cfg  = 5'($urandom_range(0, 20));
        pe_off    = 1'($urandom);
        two_level = 1'($urandom);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_now();
    rst = 1'b0;
    tag = "R1"; run(16, 0, 0);
    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      sym_msb = s[1]; sym_lsb = s[0]; sym_valid = 1'b1;
      repeat (16) begin @(negedge clk); check_now(); end
    end
    pe_off = 1; duty_cfg = 10; tag = "R6"; run(128, 0, 0);
    pe_off = 0; duty_cfg = 8;  tag = "R4"; run(128, 0, 0);
    duty_cfg = 12;             tag = "R4"; run(128, 0, 0);
    duty_cfg = 3;              tag = "R5"; run(128, 0, 0);
    duty_cfg = 20;             tag = "R5"; run(128, 0, 0);
    duty_cfg = 10; two_level = 1; tag = "R7"; run(128, 0, 0);
    two_level = 0;             tag = "R2"; run(160, 1, 0);
    tag = "R9"; run(320, 1, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule